// File: doc/BRIEF.md
# Counter with Separately Clocked Snapshot Register

This block is a binary up-counter whose value is copied into a storage register by a second, independent clock. The counter advances on its own clock while its active-low count enable is held low. An active-low clear sets it to zero. A combinational, active-low carry flags the terminal count so that a following stage can take it as its own count enable. The storage register takes a parallel copy of the whole count on each rising edge of the register clock. It is never cleared by the counter clear, so a captured value stays valid while the counter restarts.

The register drives the parallel outputs through a tri-state stage. When the active-low output enable is high, every output bit floats. When it is low, the outputs show the captured value. If both clocks are tied to one signal, the register always holds the count from before the shared edge, so it trails the counter by exactly one step.

The counter clear is sampled on the rising edge of the counter clock, in the same way as the other control inputs.

Top module: `counter_snap`

## Requirements
- R1: While `clr_n` is high and `cnt_en_n` is low, each rising edge of `cnt_clk` raises the count by one.
- R2: While `clr_n` is high and `cnt_en_n` is high, a rising edge of `cnt_clk` leaves the count unchanged.
- R3: When `clr_n` is low at a rising edge of `cnt_clk`, the count becomes 0, whatever the state of `cnt_en_n`.
- R4: `clr_n` never changes the storage register. A value captured before a clear is still on `q` after the clear.
- R5: On each rising edge of `reg_clk`, the storage register loads all bits of the current count in parallel. Between `reg_clk` edges, `q` does not follow the counter.
- R6: When `cnt_clk` and `reg_clk` rise together, the register captures the count from before that edge, which includes a clear applied at the same edge.
- R7: `rc_n` is 0 exactly when the count equals all ones (255 with the default 8-bit width) and `cnt_en_n` is 0. Otherwise it is 1.
- R8: An enabled `cnt_clk` edge at a count of 255 wraps the count to 0, and `rc_n` then returns to 1.
- R9: When `oe_n` is 1, all bits of `q` are high impedance. When `oe_n` is 0, `q` drives the storage register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cnt_clk | input | 1 | Counter clock, rising edge |
| reg_clk | input | 1 | Storage register clock, rising edge |
| cnt_en_n | input | 1 | Count enable, active low |
| clr_n | input | 1 | Counter clear, active low, sampled on `cnt_clk` |
| oe_n | input | 1 | Output enable, active low |
| q | output | WIDTH (8) | Tri-state parallel outputs of the storage register |
| rc_n | output | 1 | Terminal-count carry, active low |

## Verification
A counter clear and a register capture can fall on the same edge when both clocks are tied together. The bench raises both clocks in one cycle while `clr_n` is low, after the counter has reached a non-zero value. The register must then show that pre-clear value. A following capture on its own must show zero. The same tied-clock pulses are used without a clear to confirm that the register trails the counter by one count at every edge.

// File: rtl/counter_snap_pkg.sv
// Package: shared constants and helpers for the snapshot counter.
// Assumes: widths are at least 1 bit.
package counter_snap_pkg;

    localparam int DEFAULT_WIDTH = 8;

    // Returns an all-ones value of the given width, used as the terminal count.
    function automatic logic [63:0] terminal_of(input int width);
        return (64'd1 << width) - 64'd1;
    endfunction

endpackage

// File: rtl/snap_counter.sv
// Module: snap_counter
// Binary up-counter with an active-low enable and an active-low clear.
// The clear is sampled on the counter clock. The carry output is
// combinational and goes low at terminal count while the counter is enabled.
// Assumes: all control inputs are stable around the rising edge of cnt_clk.
module snap_counter
    import counter_snap_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic             cnt_clk,
    input  logic             cnt_en_n,
    input  logic             clr_n,
    output logic [WIDTH-1:0] count,
    output logic             rc_n
);

    localparam logic [WIDTH-1:0] TERM = WIDTH'(terminal_of(WIDTH));

    logic [WIDTH-1:0] count_q;

    // Advance, hold or clear the count on each rising edge of the counter clock.
    always_ff @(posedge cnt_clk) begin
        if (!clr_n) begin
            count_q <= '0;
        end else if (!cnt_en_n) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Flag the terminal count while counting is enabled.
    always_comb begin
        rc_n = !((count_q == TERM) && !cnt_en_n);
    end

    assign count = count_q;

    // R1
    count_step_chk: assert property (@(posedge cnt_clk) disable iff (!clr_n)
        (!cnt_en_n && count_q != TERM) |=> count_q == WIDTH'($past(count_q) + 1'b1));

    // R2
    count_hold_chk: assert property (@(posedge cnt_clk) disable iff (!clr_n)
        cnt_en_n |=> $stable(count_q));

    // R3
    count_clear_chk: assert property (@(posedge cnt_clk)
        !clr_n |=> count_q == '0);

    // R8
    count_wrap_chk: assert property (@(posedge cnt_clk) disable iff (!clr_n)
        (!cnt_en_n && count_q == TERM) |=> (count_q == '0 && rc_n));

endmodule

// File: rtl/snap_register.sv
// Module: snap_register
// Parallel storage register that copies the count on its own clock.
// It has no reset: the counter clear must not disturb a captured value.
// Assumes: cnt_i is stable around the rising edge of reg_clk.
module snap_register
    import counter_snap_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic             reg_clk,
    input  logic [WIDTH-1:0] cnt_i,
    output logic [WIDTH-1:0] store
);

    logic [WIDTH-1:0] store_q;
    logic             seen_q = 1'b0;

    // Load the whole count in parallel on each rising register-clock edge.
    always_ff @(posedge reg_clk) begin
        store_q <= cnt_i;
    end

    // Mark that a first capture has happened, so the check below has history.
    always_ff @(posedge reg_clk) begin
        seen_q <= 1'b1;
    end

    assign store = store_q;

    // R5
    capture_load_chk: assert property (@(posedge reg_clk) disable iff (!seen_q)
        store_q == $past(cnt_i));

endmodule

// File: rtl/counter_snap.sv
// Module: counter_snap (top)
// Joins the counter and the snapshot register, and drives the register
// contents onto tri-state outputs under an active-low output enable.
// Assumes: the two clocks may be independent or tied together.
module counter_snap
    import counter_snap_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic             cnt_clk,
    input  logic             reg_clk,
    input  logic             cnt_en_n,
    input  logic             clr_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] q,
    output logic             rc_n
);

    logic [WIDTH-1:0] count_w;
    logic [WIDTH-1:0] store_w;

    snap_counter #(.WIDTH(WIDTH)) i_counter (
        .cnt_clk  (cnt_clk),
        .cnt_en_n (cnt_en_n),
        .clr_n    (clr_n),
        .count    (count_w),
        .rc_n     (rc_n)
    );

    snap_register #(.WIDTH(WIDTH)) i_register (
        .reg_clk (reg_clk),
        .cnt_i   (count_w),
        .store   (store_w)
    );

    // Drive the outputs while enabled, and float them otherwise.
    assign q = oe_n ? {WIDTH{1'bz}} : store_w;

endmodule

// File: tb/test_counter_snap.sv
// Directed bench for counter_snap. Clocks are gated from a 250 MHz reference
// while it is low, and outputs are sampled on the falling edge.
module test_counter_snap;

    logic       clk = 1'b0;
    logic       cg = 1'b0;
    logic       rg = 1'b0;
    logic       cnt_en_n = 1'b0;
    logic       clr_n = 1'b0;
    logic       oe_n = 1'b0;
    wire  [7:0] q;
    wire        rc_n;
    wire        cnt_clk = clk & cg;
    wire        reg_clk = clk & rg;

    int checks = 0;
    int fails = 0;
    int exp_cnt = 0;

    counter_snap #(.WIDTH(8)) i_counter_snap (
        .cnt_clk  (cnt_clk),
        .reg_clk  (reg_clk),
        .cnt_en_n (cnt_en_n),
        .clr_n    (clr_n),
        .oe_n     (oe_n),
        .q        (q),
        .rc_n     (rc_n)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic c, input logic r, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cg = c;
            rg = r;
            @(negedge clk);
            cg = 1'b0;
            rg = 1'b0;
            if (c) begin
                if (!clr_n) exp_cnt = 0;
                else if (!cnt_en_n) exp_cnt = (exp_cnt + 1) % 256;
            end
        end
        #1;
    endtask

    task automatic t_reset();
        clr_n = 1'b0;
        pulse(1'b1, 1'b0, 1);
        clr_n = 1'b1;
        pulse(1'b0, 1'b1, 1);
        check("R3 reset count", q, 8'd0);
        check("R7 carry idle", {7'd0, rc_n}, 8'd1);
    endtask

    task automatic t_count();
        cnt_en_n = 1'b0;
        pulse(1'b1, 1'b0, 7);
        pulse(1'b0, 1'b1, 1);
        check("R1 count 7", q, 8'd7);
        pulse(1'b1, 1'b0, 3);
        check("R5 no capture without reg_clk", q, 8'd7);
        pulse(1'b0, 1'b1, 1);
        check("R5 capture 10", q, 8'(exp_cnt));
    endtask

    task automatic t_hold();
        cnt_en_n = 1'b1;
        pulse(1'b1, 1'b0, 4);
        pulse(1'b0, 1'b1, 1);
        check("R2 hold", q, 8'd10);
        check("R7 carry off when disabled", {7'd0, rc_n}, 8'd1);
        cnt_en_n = 1'b0;
    endtask

    task automatic t_clear_keeps();
        clr_n = 1'b0;
        pulse(1'b1, 1'b0, 1);
        check("R4 register kept over clear", q, 8'd10);
        clr_n = 1'b1;
        pulse(1'b0, 1'b1, 1);
        check("R3 clear beats enable", q, 8'd0);
    endtask

    task automatic t_tied();
        for (int k = 0; k < 3; k++) begin
            pulse(1'b1, 1'b1, 1);
            check("R6 register one behind", q, 8'(k));
        end
        clr_n = 1'b0;
        pulse(1'b1, 1'b1, 1);
        check("R6 same-edge clear and capture", q, 8'd3);
        clr_n = 1'b1;
        pulse(1'b0, 1'b1, 1);
        check("R4 cleared count captured later", q, 8'd0);
    endtask

    task automatic t_wrap();
        pulse(1'b1, 1'b0, 254);
        check("R7 carry idle at 254", {7'd0, rc_n}, 8'd1);
        pulse(1'b1, 1'b0, 1);
        check("R7 carry at 255", {7'd0, rc_n}, 8'd0);
        cnt_en_n = 1'b1;
        #1;
        check("R7 carry gated by enable", {7'd0, rc_n}, 8'd1);
        cnt_en_n = 1'b0;
        #1;
        pulse(1'b1, 1'b0, 1);
        check("R8 carry released after wrap", {7'd0, rc_n}, 8'd1);
        pulse(1'b0, 1'b1, 1);
        check("R8 wrap to 0", q, 8'd0);
        pulse(1'b1, 1'b0, 1);
        pulse(1'b0, 1'b1, 1);
        check("R8 counts on after wrap", q, 8'd1);
    endtask

    task automatic t_oe();
        oe_n = 1'b1;
        #1;
        check("R9 outputs float", q, 8'bzzzzzzzz);
        oe_n = 1'b0;
        #1;
        check("R9 outputs drive", q, 8'd1);
    endtask

    initial begin
        t_reset();
        t_count();
        t_hold();
        t_clear_keeps();
        t_tied();
        t_wrap();
        t_oe();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule